// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block copies a block of words between a peripheral and system memory without the processor doing the moves. The processor uses a small register port to set up a job. A job has a direction, a peripheral address, a first memory address and a word count. Setting a go bit starts the job. The engine then moves one word per handshake and keeps its own address and count. When the last word has moved it raises an interrupt line.

The job runs in a state machine with six states. `ST_IDLE` waits for a go write. A go write with a count of zero goes straight to `ST_FINISH`. Otherwise the direction bit selects the first state. For memory-to-device (direction 0) the engine moves from `ST_MEM_RD` to `ST_DEV_WR` and back. For device-to-memory (direction 1) it moves from `ST_DEV_RD` to `ST_MEM_WR` and back. The memory-side state waits for `mem_gnt`, and the device-side state waits for `dev_rdy`. The handshake that finishes a word also steps the address and the count. If that word was the last, the engine enters `ST_FINISH`, which sets the interrupt and returns to `ST_IDLE`.

Register map (3-bit register address, `reg_rdata` read combinationally): 0 control (bit 0 direction, bit 1 go, write-only pulse); 1 peripheral address; 2 memory address (live); 3 remaining count (live); 4 status (bit 0 busy, bit 1 interrupt pending; writing 1 to bit 1 clears it). Unused bits and addresses 5 to 7 read 0.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and `mem_req`, `dev_rd` and `dev_wr` are all 0.
- R2: The peripheral address, memory address, count and direction written while idle read back unchanged at register addresses 1, 2, 3 and 0.
- R3: Writing address 0 with bit 1 set while idle starts a job. In the next cycle status bit 0 (busy) reads 1.
- R4: With direction 0, each word is read from memory at the current address. `mem_req` is held with `mem_we` low, and the data is taken from `mem_rdata` in the cycle `mem_gnt` is high. The word is then driven on `dev_wdata` with `dev_wr` held until `dev_rdy` is high.
- R5: With direction 1, `dev_rd` is held until `dev_rdy` is high, and the word on `dev_rdata` in that cycle is taken. It is then written to memory at the current address, with `mem_req` and `mem_we` held until `mem_gnt` is high.
- R6: Each completed word increments the memory address by one and decrements the count by one. After a job of N words, address 2 reads start+N (modulo 2^16) and address 3 reads 0.
- R7: `dev_addr` carries the programmed peripheral address in every cycle that `dev_rd` or `dev_wr` is high.
- R8: At most one of `mem_req`, `dev_rd` and `dev_wr` is high in any cycle. A `mem_req` that has not been granted stays high in the next cycle.
- R9: `irq` rises exactly two clock edges after the edge that ends the last word's handshake, and busy reads 0 from that point.
- R10: A go write with count 0 raises `irq` two edges later. Busy reads 1 for exactly one cycle, and no memory or device strobe is issued.
- R11: `irq` stays high until address 4 is written with bit 1 set. A status write with bit 1 clear leaves `irq` unchanged.
- R12: While busy, writes to addresses 0 to 3 are ignored. The running job keeps its peripheral address and word count, and a second go does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant; access completes in this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with grant |
| dev_addr | output | DEV_W | Peripheral address |
| dev_rd | output | 1 | Peripheral read strobe |
| dev_wr | output | 1 | Peripheral write strobe |
| dev_rdy | input | 1 | Peripheral ready; strobe completes in this cycle |
| dev_wdata | output | DATA_W | Data to peripheral |
| dev_rdata | input | DATA_W | Data from peripheral, valid with ready |
| irq | output | 1 | Job-complete interrupt |

## Verification
The bench builds the engine with its default parameters: 16-bit data, memory address and count, and an 8-bit peripheral address. With these widths the address and count registers can hold any value the bench writes over the register port. A memory start address near 0xFF runs past the bench memory's 256-word window while the 16-bit address register keeps counting. The bench varies the memory grant latency and the device ready latency independently, from 0 to 4 cycles. These settings cover both handshake states at their shortest and longest waits. They also leave the engine busy long enough to test config writes that must be ignored.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_RD,
        ST_DEV_WR,
        ST_DEV_RD,
        ST_MEM_WR,
        ST_FINISH
    } dma_state_e;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_DEV   = 3'd1;
    localparam logic [REG_AW-1:0] RA_MADDR = 3'd2;
    localparam logic [REG_AW-1:0] RA_COUNT = 3'd3;
    localparam logic [REG_AW-1:0] RA_STAT  = 3'd4;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IRQ_BIT  = 1;

endpackage

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
    import blk_dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic              go,
    output logic              go_dir,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic              dir_q;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              irq_q;
    logic              cfg_wr;
    logic              irq_clr;

    assign cfg_wr  = reg_wr && !busy;
    assign irq_clr = reg_wr && (reg_addr == RA_STAT) && reg_wdata[STAT_IRQ_BIT];
    assign go      = cfg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_GO_BIT];
    assign go_dir  = reg_wdata[CTRL_DIR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            dev_q  <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_ONE;
            cnt_q  <= cnt_q - CNT_ONE;
        end else if (cfg_wr) begin
            case (reg_addr)
                RA_CTRL:  dir_q  <= reg_wdata[CTRL_DIR_BIT];
                RA_DEV:   dev_q  <= reg_wdata[DEV_W-1:0];
                RA_MADDR: addr_q <= reg_wdata[ADDR_W-1:0];
                RA_COUNT: cnt_q  <= reg_wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (finish)  irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata[CTRL_DIR_BIT] = dir_q;
            RA_DEV:   reg_rdata[DEV_W-1:0]    = dev_q;
            RA_MADDR: reg_rdata[ADDR_W-1:0]   = addr_q;
            RA_COUNT: reg_rdata[CNT_W-1:0]    = cnt_q;
            RA_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = busy;
                reg_rdata[STAT_IRQ_BIT]  = irq_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign dev_addr = dev_q;
    assign cur_addr = addr_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_ONE);
    assign irq      = irq_q;

    // R6
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == $past(addr_q) + ADDR_ONE) && (cnt_q == $past(cnt_q) - CNT_ONE));

    // R12
    busy_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == RA_DEV)) |=> $stable(dev_q));

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);

endmodule

// File: rtl/blk_dma_fsm.sv
module blk_dma_fsm
    import blk_dma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_dir,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_rdy,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              busy,
    output logic              step,
    output logic              finish,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata
);

    dma_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (cnt_zero)    state_d = ST_FINISH;
                    else if (go_dir) state_d = ST_DEV_RD;
                    else             state_d = ST_MEM_RD;
                end
            end
            ST_MEM_RD: if (mem_gnt) state_d = ST_DEV_WR;
            ST_DEV_WR: if (dev_rdy) state_d = cnt_last ? ST_FINISH : ST_MEM_RD;
            ST_DEV_RD: if (dev_rdy) state_d = ST_MEM_WR;
            ST_MEM_WR: if (mem_gnt) state_d = cnt_last ? ST_FINISH : ST_DEV_RD;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               hold_q <= '0;
        else if ((state_q == ST_MEM_RD) && mem_gnt) hold_q <= mem_rdata;
        else if ((state_q == ST_DEV_RD) && dev_rdy) hold_q <= dev_rdata;
    end

    always_comb begin
        busy    = 1'b1;
        step    = 1'b0;
        finish  = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        dev_rd  = 1'b0;
        dev_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_MEM_RD: mem_req = 1'b1;
            ST_DEV_WR: begin
                dev_wr = 1'b1;
                step   = dev_rdy;
            end
            ST_DEV_RD: dev_rd = 1'b1;
            ST_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = mem_gnt;
            end
            ST_FINISH: finish = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign mem_wdata = hold_q;
    assign dev_wdata = hold_q;

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we)));

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && cnt_zero) |=> (finish && !mem_req && !dev_rd && !dev_wr));

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
    import blk_dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    output logic              dev_rd,
    output logic              dev_wr,
    input  logic              dev_rdy,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              irq
);

    logic busy, step, finish, go, go_dir, cnt_zero, cnt_last;

    blk_dma_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .step     (step),
        .finish   (finish),
        .go       (go),
        .go_dir   (go_dir),
        .dev_addr (dev_addr),
        .cur_addr (mem_addr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .irq      (irq)
    );

    blk_dma_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_dir   (go_dir),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .mem_gnt  (mem_gnt),
        .mem_rdata(mem_rdata),
        .dev_rdy  (dev_rdy),
        .dev_rdata(dev_rdata),
        .busy     (busy),
        .step     (step),
        .finish   (finish),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .dev_rd   (dev_rd),
        .dev_wr   (dev_wr),
        .dev_wdata(dev_wdata)
    );

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_req, dev_rd, dev_wr}) <= 1);

    // R9
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

endmodule

// File: tb/blk_dma_engine_test.sv
module blk_dma_engine_test;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int VW = 8;
    localparam int NV = 5;
    // fields: [32] dir, [31:24] dev, [23:16] mem start, [15:8] count, [7:4] grant wait, [3:0] ready wait
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h11, 8'h10, 8'd4, 4'd0, 4'd0},
        {1'b1, 8'h22, 8'h40, 8'd5, 4'd2, 4'd1},
        {1'b0, 8'h33, 8'hFE, 8'd3, 4'd1, 4'd3},
        {1'b1, 8'h44, 8'h80, 8'd1, 4'd0, 4'd2},
        {1'b1, 8'h5A, 8'h00, 8'd8, 4'd3, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mem_req, mem_we, dev_rd, dev_wr, irq;
    logic          mem_gnt = 1'b0;
    logic          dev_rdy = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, dev_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] dev_rdata = '0;
    logic [VW-1:0] dev_addr;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] cap [256];
    int cap_n, mem_wr_n, src_i, gwait, rwait, gcnt, rcnt;
    int dev_addr_bad, excl_bad, strobe_n, cyc, last_hs, irq_cyc;
    logic [VW-1:0] exp_dev;
    logic prev_irq = 1'b0;

    blk_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_rdy(dev_rdy),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] init_word(input int a);
        return 16'h0100 + 16'((a & 255) * 3);
    endfunction

    function automatic logic [DW-1:0] src_word(input logic [VW-1:0] d, input int i);
        return 16'hA000 + 16'(int'(d) * 16) + 16'(i);
    endfunction

    // memory and device models, driven away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if ((int'(mem_req) + int'(dev_rd) + int'(dev_wr)) > 1) excl_bad = excl_bad + 1;
        if (mem_req || dev_rd || dev_wr) strobe_n = strobe_n + 1;
        if ((dev_rd || dev_wr) && (dev_addr != exp_dev)) dev_addr_bad = dev_addr_bad + 1;
        if (mem_req) begin
            if (gcnt >= gwait) begin
                mem_gnt = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    mem_wr_n = mem_wr_n + 1;
                end
                gcnt = 0;
                last_hs = cyc;
            end else begin
                mem_gnt = 1'b0;
                gcnt = gcnt + 1;
            end
        end else begin
            mem_gnt = 1'b0;
            gcnt = 0;
        end
        if (dev_rd || dev_wr) begin
            if (rcnt >= rwait) begin
                dev_rdy = 1'b1;
                if (dev_rd) begin
                    dev_rdata = src_word(exp_dev, src_i);
                    src_i = src_i + 1;
                end else begin
                    cap[cap_n[7:0]] = dev_wdata;
                    cap_n = cap_n + 1;
                end
                rcnt = 0;
                last_hs = cyc;
            end else begin
                dev_rdy = 1'b0;
                rcnt = rcnt + 1;
            end
        end else begin
            dev_rdy = 1'b0;
            rcnt = 0;
        end
        if (irq && !prev_irq) irq_cyc = cyc;
        prev_irq = irq;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq();
        int n = 0;
        #1;
        while (!irq && n < 3000) begin
            @(negedge clk);
            #1;
            n = n + 1;
        end
        chk(irq == 1'b1, "R9 irq before timeout", int'(irq), 1);
    endtask

    task automatic prep(input logic [VW-1:0] d, input int gd, input int rd);
        for (int i = 0; i < 256; i++) mem[i] = init_word(i);
        cap_n = 0; mem_wr_n = 0; src_i = 0;
        dev_addr_bad = 0; excl_bad = 0;
        exp_dev = d; gwait = gd; rwait = rd;
    endtask

    initial begin
        cap_n = 0; mem_wr_n = 0; src_i = 0; gwait = 0; rwait = 0; gcnt = 0; rcnt = 0;
        dev_addr_bad = 0; excl_bad = 0; strobe_n = 0; cyc = 0; last_hs = 0; irq_cyc = 0;
        exp_dev = '0;
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rv;
        int mism;
        int hs;
        int sn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), rv);
            chk(rv == '0, "R1 register reset", int'(rv), 0);
        end
        chk(!irq && !mem_req && !dev_rd && !dev_wr, "R1 outputs idle",
            int'({irq, mem_req, dev_rd, dev_wr}), 0);

        // main vector walk
        for (int v = 0; v < NV; v++) begin
            logic          dir;
            logic [VW-1:0] dv;
            int            ma, cn;
            dir = VEC[v][32];
            dv  = VEC[v][31:24];
            ma  = int'(VEC[v][23:16]);
            cn  = int'(VEC[v][15:8]);
            prep(dv, int'(VEC[v][7:4]), int'(VEC[v][3:0]));
            reg_write(3'd1, DW'(dv));
            reg_write(3'd2, DW'(ma));
            reg_write(3'd3, DW'(cn));
            reg_write(3'd0, DW'(dir));
            reg_read(3'd0, rv);
            chk(rv == DW'(dir), "R2 direction readback", int'(rv), int'(dir));
            reg_read(3'd1, rv);
            chk(rv == DW'(dv), "R2 device readback", int'(rv), int'(dv));
            reg_read(3'd2, rv);
            chk(rv == DW'(ma), "R2 address readback", int'(rv), ma);
            reg_read(3'd3, rv);
            chk(rv == DW'(cn), "R2 count readback", int'(rv), cn);
            reg_write(3'd0, DW'(2) | DW'(dir));
            reg_read(3'd4, rv);
            chk(rv[0] == 1'b1, "R3 busy after go", int'(rv[0]), 1);
            wait_irq();
            chk(irq_cyc == last_hs + 2, "R9 irq timing", irq_cyc - last_hs, 2);
            reg_read(3'd4, rv);
            chk(rv[1:0] == 2'b10, "R9 status at done", int'(rv[1:0]), 2);
            mism = 0;
            if (!dir) begin
                for (int i = 0; i < cn; i++)
                    if (cap[i] != init_word(ma + i)) mism = mism + 1;
                chk(mism == 0 && cap_n == cn, "R4 words to device", cap_n - mism, cn);
            end else begin
                for (int i = 0; i < cn; i++)
                    if (mem[(ma + i) & 255] != src_word(dv, i)) mism = mism + 1;
                chk(mism == 0 && mem_wr_n == cn, "R5 words to memory", mem_wr_n - mism, cn);
            end
            reg_read(3'd2, rv);
            chk(rv == DW'(ma + cn), "R6 final address", int'(rv), ma + cn);
            reg_read(3'd3, rv);
            chk(rv == '0, "R6 final count", int'(rv), 0);
            chk(dev_addr_bad == 0, "R7 device address", dev_addr_bad, 0);
            chk(excl_bad == 0, "R8 single strobe", excl_bad, 0);
            reg_write(3'd4, DW'(2));
        end

        // R10 zero count
        prep(8'h07, 0, 0);
        reg_write(3'd3, DW'(0));
        sn = strobe_n;
        reg_write(3'd0, DW'(2));
        reg_read(3'd4, rv);
        chk(rv[1:0] == 2'b01, "R10 busy one cycle", int'(rv[1:0]), 1);
        @(negedge clk);
        reg_read(3'd4, rv);
        chk(rv[1:0] == 2'b10, "R10 irq without transfer", int'(rv[1:0]), 2);
        chk(strobe_n == sn, "R10 no strobes", strobe_n - sn, 0);

        // R11 clear behaviour
        reg_write(3'd4, DW'(1));
        repeat (3) @(negedge clk);
        #1;
        chk(irq == 1'b1, "R11 irq held", int'(irq), 1);
        reg_write(3'd4, DW'(2));
        #1;
        chk(irq == 1'b0, "R11 irq cleared", int'(irq), 0);

        // R12 writes while busy
        prep(8'h3C, 4, 4);
        reg_write(3'd1, DW'(8'h3C));
        reg_write(3'd2, DW'(16'h0020));
        reg_write(3'd3, DW'(6));
        reg_write(3'd0, DW'(2));
        reg_write(3'd1, DW'(8'h99));
        reg_write(3'd3, DW'(16'h0040));
        reg_write(3'd2, DW'(16'h0000));
        reg_write(3'd0, DW'(3));
        reg_read(3'd0, rv);
        chk(rv == '0, "R12 direction kept", int'(rv), 0);
        wait_irq();
        reg_read(3'd1, rv);
        chk(rv == DW'(8'h3C), "R12 device kept", int'(rv), 16'h3C);
        chk(cap_n == 6 && mem_wr_n == 0, "R12 count kept", cap_n, 6);
        reg_read(3'd2, rv);
        chk(rv == DW'(16'h0026), "R12 address kept", int'(rv), 16'h26);
        chk(dev_addr_bad == 0, "R12 device address", dev_addr_bad, 0);
        hs = cyc;
        repeat (4) @(negedge clk);
        reg_read(3'd4, rv);
        chk(rv[0] == 1'b0 && cyc > hs, "R12 no second job", int'(rv[0]), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule